// File: doc/BRIEF.md
# Byte Permutation Crossbar

This block rearranges the bytes of a wide data word. Each destination byte picks one source byte through its own 5-bit index, so any byte can land anywhere, and one byte can be copied into several places. The indices form a permutation vector of one index per destination byte.

The vector has two possible sources. It can come from a second wide operand, where each byte of that operand supplies the index for the destination byte in the same position. It can also come from a small fixed table of common patterns, chosen by a 3-bit entry number. The table covers identity, full reversal, endian swaps and small transposes.

The result is captured in one output register, and a valid flag travels with it. A result appears one clock after the input is presented. A parameter can remove the register to give a purely combinational path.

Top module: `bperm_unit`

## Requirements
- R1: While rst_n is low, outValid is 0 and outWord is all zeros.
- R2: When inValid is 1 at a rising clock edge, outValid is 1 after that edge. outWord then holds the permuted word built from the inputs sampled at that edge.
- R3: When inValid is 0 at a rising clock edge, outValid is 0 after that edge. outWord keeps its previous value, whatever the other inputs are.
- R4: Destination byte i (bits 8*i+7 down to 8*i, byte 0 least significant) equals source byte k, where k is the index for lane i.
- R5: When the vector comes from vecWord, the index for lane i is bits 8*i+4 down to 8*i of vecWord. Bits 8*i+7 down to 8*i+5 have no effect.
- R6: Several lanes may carry the same index, and each of them receives a copy of that source byte.
- R7: When useTable is 1, vecWord has no effect and the vector comes from table entry tableIdx. When useTable is 0, tableIdx has no effect and the vector comes from vecWord.
- R8: Table entries 0 to 3 give these indices for lane i:
  - entry 0 (identity): i
  - entry 1 (full reversal): 31-i
  - entry 2 (byte swap inside each 32-bit word): 4*(i/4)+3-(i%4)
  - entry 3 (16-bit halves swapped inside each 32-bit word): 4*(i/4)+((i%4)+2)%4
- R9: Table entries 4 to 7 give these indices for lane i:
  - entry 4: a 4x4 byte transpose inside each 128-bit half, 16*(i/16)+4*(i%4)+(i%16)/4.
  - entry 5: a 4x4 transpose of 16-bit elements over the whole word. With h=i/2, the index is 2*(4*(h%4)+h/4)+i%2.
  - entry 6: a 2x2 transpose of 32-bit elements inside each 128-bit half. This exchanges words 1 and 2 of each half.
  - entry 7: a broadcast of byte 0, so every index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Inputs carry a request this cycle |
| srcWord | input | 256 | Source data word |
| vecWord | input | 256 | Permutation vector operand, one index byte per lane |
| useTable | input | 1 | 1 selects the fixed table, 0 selects vecWord |
| tableIdx | input | 3 | Table entry number |
| outValid | output | 1 | outWord holds a new result |
| outWord | output | 256 | Permuted word |

## Verification
Both outValid and outWord change exactly one rising edge after the edge that samples a request. Idle cycles must leave outWord unchanged at that same point.

The bench applies each stimulus at a falling edge and computes the expected pair from its own byte model at that moment. It then compares the outputs at the next falling edge, which is half a period after the capturing edge. Because every cycle is compared, a result that arrives early, late, or that disturbs the held word on an idle cycle is reported.

// File: rtl/bperm_pkg.sv
package bperm_pkg;

  // Strobes passed from the control half to the datapath half.
  typedef struct packed {
    logic capture;   // load the output register this cycle
    logic useTable;  // vector comes from the fixed table
  } permStrobes_t;

  localparam int TABLE_SIZE  = 8;
  localparam int TABLE_SEL_W = $clog2(TABLE_SIZE);

endpackage

// File: rtl/bperm_ctrl.sv
module bperm_ctrl
  import bperm_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inValid,
  input  logic         useTable,
  output permStrobes_t strobes,
  output logic         outValid
);

  always_comb begin
    strobes.capture  = inValid;
    strobes.useTable = useTable;
  end

  generate
    if (REGISTERED) begin : g_reg
      logic validQ;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) validQ <= 1'b0;
        else        validQ <= inValid;
      end

      assign outValid = validQ;

      AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        inValid |=> outValid);  // R2
      AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !inValid |=> !outValid);  // R3

      always @(negedge clk) begin
        if (!rst_n) begin
          AST_RESET_CLEAR: assert (!outValid);  // R1
        end
      end
    end else begin : g_comb
      assign outValid = inValid;
    end
  endgenerate

endmodule

// File: rtl/bperm_xbar.sv
module bperm_xbar #(
  parameter int NUM_BYTES = 32,
  parameter int BYTE_W    = 8,
  parameter int IDX_W     = $clog2(NUM_BYTES)
) (
  input  logic [NUM_BYTES*BYTE_W-1:0] srcWord,
  input  logic [NUM_BYTES*IDX_W-1:0]  laneSel,
  output logic [NUM_BYTES*BYTE_W-1:0] permWord
);

  // One full-width byte selector per destination lane.
  for (genvar lane = 0; lane < NUM_BYTES; lane++) begin : g_lane
    logic [IDX_W-1:0] pick;
    assign pick = laneSel[lane*IDX_W +: IDX_W];
    assign permWord[lane*BYTE_W +: BYTE_W] = srcWord[int'(pick)*BYTE_W +: BYTE_W];
  end

endmodule

// File: rtl/bperm_dpath.sv
module bperm_dpath
  import bperm_pkg::*;
#(
  parameter int NUM_BYTES  = 32,
  parameter int BYTE_W     = 8,
  parameter bit REGISTERED = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  permStrobes_t                strobes,
  input  logic [NUM_BYTES*BYTE_W-1:0] srcWord,
  input  logic [NUM_BYTES*BYTE_W-1:0] vecWord,
  input  logic [TABLE_SEL_W-1:0]      tableIdx,
  output logic [NUM_BYTES*BYTE_W-1:0] outWord
);

  localparam int IDX_W  = $clog2(NUM_BYTES);
  localparam int WORD_W = NUM_BYTES * BYTE_W;

  // Fixed pattern generator: source index for one lane under one entry.
  // Patterns rewrite lane-number bits, so they assume at least 32 lanes.
  function automatic logic [IDX_W-1:0] tableSource(
    input logic [TABLE_SEL_W-1:0] entry,
    input logic [IDX_W-1:0]       lane
  );
    logic [IDX_W-1:0] t;
    t = lane;
    case (entry)
      3'd0: t = lane;
      3'd1: t = ~lane;
      3'd2: t = lane ^ IDX_W'(3);
      3'd3: t = lane ^ IDX_W'(2);
      3'd4: t[3:0] = {lane[1:0], lane[3:2]};
      3'd5: t[4:1] = {lane[2:1], lane[4:3]};
      3'd6: t[3:2] = {lane[2], lane[3]};
      default: t = '0;
    endcase
    return t;
  endfunction

  logic [NUM_BYTES*IDX_W-1:0] laneSel;
  logic [WORD_W-1:0]          permWord;

  for (genvar lane = 0; lane < NUM_BYTES; lane++) begin : g_sel
    logic [BYTE_W-1:0] vecByte;
    logic [IDX_W-1:0]  regSel;
    logic [IDX_W-1:0]  tblSel;
    assign vecByte = vecWord[lane*BYTE_W +: BYTE_W];
    assign regSel  = IDX_W'(vecByte);
    assign tblSel  = tableSource(tableIdx, IDX_W'(lane));
    assign laneSel[lane*IDX_W +: IDX_W] = strobes.useTable ? tblSel : regSel;
  end

  bperm_xbar #(
    .NUM_BYTES (NUM_BYTES),
    .BYTE_W    (BYTE_W),
    .IDX_W     (IDX_W)
  ) u_xbar (
    .srcWord  (srcWord),
    .laneSel  (laneSel),
    .permWord (permWord)
  );

  generate
    if (REGISTERED) begin : g_reg
      logic [WORD_W-1:0] wordQ;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               wordQ <= '0;
        else if (strobes.capture) wordQ <= permWord;
      end

      assign outWord = wordQ;

      AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !strobes.capture |=> $stable(outWord));  // R3
      AST_TABLE_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
        (strobes.capture && strobes.useTable && tableIdx == 3'd0)
          |=> outWord == $past(srcWord));  // R8
      AST_TABLE_BROADCAST: assert property (@(posedge clk) disable iff (!rst_n)
        (strobes.capture && strobes.useTable && tableIdx == 3'd7)
          |=> outWord == {NUM_BYTES{$past(srcWord[BYTE_W-1:0])}});  // R9

      always @(negedge clk) begin
        if (!rst_n) begin
          AST_RESET_WORD: assert (outWord == '0);  // R1
        end
      end
    end else begin : g_comb
      assign outWord = permWord;
    end
  endgenerate

endmodule

// File: rtl/bperm_unit.sv
module bperm_unit
  import bperm_pkg::*;
#(
  parameter int NUM_BYTES  = 32,
  parameter int BYTE_W     = 8,
  parameter bit REGISTERED = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        inValid,
  input  logic [NUM_BYTES*BYTE_W-1:0] srcWord,
  input  logic [NUM_BYTES*BYTE_W-1:0] vecWord,
  input  logic                        useTable,
  input  logic [TABLE_SEL_W-1:0]      tableIdx,
  output logic                        outValid,
  output logic [NUM_BYTES*BYTE_W-1:0] outWord
);

  permStrobes_t strobes;

  bperm_ctrl #(
    .REGISTERED (REGISTERED)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .useTable (useTable),
    .strobes  (strobes),
    .outValid (outValid)
  );

  bperm_dpath #(
    .NUM_BYTES  (NUM_BYTES),
    .BYTE_W     (BYTE_W),
    .REGISTERED (REGISTERED)
  ) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .srcWord  (srcWord),
    .vecWord  (vecWord),
    .tableIdx (tableIdx),
    .outWord  (outWord)
  );

endmodule

// File: tb/bperm_unit_tb.sv
module bperm_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 32;
  localparam int W  = NB * 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         inValid = 1'b0;
  logic         useTable = 1'b0;
  logic [2:0]   tableIdx = '0;
  logic [W-1:0] srcWord = '0;
  logic [W-1:0] vecWord = '0;
  logic         outValid;
  logic [W-1:0] outWord;

  logic         expValid = 1'b0;
  logic [W-1:0] expWord = '0;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bperm_unit u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .srcWord  (srcWord),
    .vecWord  (vecWord),
    .useTable (useTable),
    .tableIdx (tableIdx),
    .outValid (outValid),
    .outWord  (outWord)
  );

  // Source index of lane i under table entry e, in arithmetic form.
  function automatic int refIndex(int e, int i);
    int h;
    int w;
    h = i / 2;
    w = (i % 16) / 4;
    case (e)
      0: return i;
      1: return 31 - i;
      2: return 4*(i/4) + 3 - (i%4);
      3: return 4*(i/4) + ((i%4) + 2) % 4;
      4: return 16*(i/16) + 4*(i%4) + (i%16)/4;
      5: return 2*(4*(h%4) + h/4) + i%2;
      6: return 16*(i/16) + 4*((w == 1) ? 2 : (w == 2) ? 1 : w) + i%4;
      default: return 0;
    endcase
  endfunction

  function automatic logic [W-1:0] tableVector(int e);
    logic [W-1:0] v;
    v = '0;
    for (int i = 0; i < NB; i++) v[i*8 +: 8] = 8'(refIndex(e, i));
    return v;
  endfunction

  function automatic logic [W-1:0] refPerm(logic [W-1:0] src, logic [W-1:0] vec);
    logic [W-1:0] r;
    for (int i = 0; i < NB; i++) r[i*8 +: 8] = src[(int'(vec[i*8 +: 8]) % NB)*8 +: 8];
    return r;
  endfunction

  function automatic logic [W-1:0] randWord();
    logic [W-1:0] r;
    for (int k = 0; k < W/32; k++) r[k*32 +: 32] = $urandom;
    return r;
  endfunction

  function automatic logic [W-1:0] randVector(bit dirtyHigh);
    logic [W-1:0] v;
    for (int i = 0; i < NB; i++)
      v[i*8 +: 8] = {(dirtyHigh ? 3'($urandom) : 3'd0), 5'($urandom)};
    return v;
  endfunction

  task automatic compare(string tag);
    checks++;
    if (outValid !== expValid || outWord !== expWord) begin
      fails++;
      $display("FAIL %s: outValid=%0b outWord=%h expected outValid=%0b outWord=%h",
               tag, outValid, outWord, expValid, expWord);
    end
  endtask

  // Called at a falling edge; one clock per call, compared every clock.
  task automatic step(string tag, bit v, logic [W-1:0] src, logic [W-1:0] vec,
                      bit ut, int ti);
    inValid  = v;
    srcWord  = src;
    vecWord  = vec;
    useTable = ut;
    tableIdx = 3'(ti);
    if (v) expWord = refPerm(src, ut ? tableVector(ti) : vec);
    expValid = v;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog: outValid=%0b expected run to finish", outValid);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    repeat (2) @(negedge clk);
    compare("R1 reset state");
    // Inputs moving under reset must not disturb the cleared outputs
    inValid = 1'b1;
    srcWord = randWord();
    @(negedge clk);
    compare("R1 reset with activity");
    inValid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release");

    step("R4 identity via vecWord", 1, randWord(), tableVector(0), 0, 5);
    for (int n = 0; n < 20; n++) step("R4 random vector", 1, randWord(), randVector(0), 0, 0);
    for (int n = 0; n < 10; n++) step("R5 upper index bits ignored", 1, randWord(), randVector(1), 0, 0);

    for (int i = 0; i < NB; i++) v[i*8 +: 8] = 8'd9;
    step("R6 all lanes same byte", 1, randWord(), v, 0, 0);
    for (int i = 0; i < NB; i++) v[i*8 +: 8] = 8'(i / 4);
    step("R6 grouped duplicates", 1, randWord(), v, 0, 0);

    for (int n = 0; n < 6; n++) step("R3 idle holds word", 0, randWord(), randWord(), n % 2, n);
    for (int n = 0; n < 8; n++) step("R2 back-to-back", 1, randWord(), randVector(1), 0, 0);
    step("R3 single idle", 0, randWord(), randWord(), 1, 7);

    for (int e = 0; e < 4; e++) step("R8 table entry", 1, randWord(), randWord(), 1, e);
    for (int e = 4; e < 8; e++) step("R9 table entry", 1, randWord(), randWord(), 1, e);

    for (int n = 0; n < 16; n++) begin
      step("R7 vecWord ignored", 1, randWord(), randWord(), 1, n % 8);
      step("R7 tableIdx ignored", 1, randWord(), randVector(0), 0, $urandom % 8);
    end

    step("R3 idle after table", 0, '0, '0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule